// File: doc/BRIEF.md
# Mode-Selected JTAG Bit Shifter

This block is a JTAG master that executes a stream of host commands. Each command picks a pin mode, a clock count and the data bits for those clocks. The block drives TCK, TMS and TDI and can capture TDO. A single mode can step the TAP state machine on TMS while TDI stays at a chosen level. Another mode can shift a bit string into TDI while TMS stays fixed. Two further modes drive both lines from the data, and one of these also returns the sampled TDO bits as bytes.

Commands arrive as bytes on a valid/ready input. Each command is a header byte, then a 16-bit clock count (low byte first), then the packed data bytes. Captured TDO leaves on a byte output marked by a one-cycle valid strobe. A half-period input sets how many system clocks TCK spends in each phase. When the next data byte is late, TCK simply waits low until it arrives.

Top module: `jtag_bit_shifter`

## Requirements
- R1: After reset, tck is 0, tms is 1, tdi is 0, out_valid is 0 and in_ready is 1.
- R2: A command is a header byte, then a count of CNT_W/8 bytes sent least significant byte first, then the data bytes. In the header, bits [1:0] select the mode, bit 2 is the hold level and bits [7:3] are ignored.
- R3: Mode 0 drives one data bit per clock onto TMS, least significant bit of each byte first, and holds TDI at the hold level.
- R4: Mode 1 drives one data bit per clock onto TDI, least significant bit first, and holds TMS at the hold level.
- R5: Modes 2 and 3 use four clocks per data byte. Clock k of a byte puts bit 2k on TDI and bit 2k+1 on TMS.
- R6: Mode 3 samples TDO at each TCK rising edge and packs the samples into bytes, least significant bit first. A byte is emitted when eight bits have been collected or the command ends, and a partial byte is zero padded. out_valid pulses for one cycle, in the same cycle that TCK rises. Modes 0 to 2 emit nothing.
- R7: TCK stays high for exactly H system clocks and low for at least H, where H is half_period and a value of 0 counts as 1. TMS and TDI never change while TCK is high or at its rising edge.
- R8: A count of zero produces no TCK pulses, consumes no data bytes and emits no output. The next byte is read as a header.
- R9: When the count ends partway through a data byte, the unused bits of that byte are discarded and the next byte is read as a header.
- R10: in_ready is low whenever TCK is high.
- R11: With a standard TAP on the pins, five TMS ones followed by 0,1,0,0 (mode 0) and then a 32-clock mode 3 capture return the device's 32-bit identification word, low byte first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Command stream byte |
| in_valid | input | 1 | in_data holds a byte |
| in_ready | output | 1 | Block accepts a byte this cycle |
| half_period | input | HP_W | System clocks per TCK phase (0 acts as 1) |
| tck | output | 1 | JTAG test clock |
| tms | output | 1 | JTAG mode select |
| tdi | output | 1 | JTAG data to device |
| tdo | input | 1 | JTAG data from device |
| out_data | output | 8 | Captured TDO byte |
| out_valid | output | 1 | One-cycle strobe for out_data |

## Verification
The hardest case to reach is a capture that ends partway through a byte while TCK is stalled low waiting for a late data byte. The stimulus forces it by spacing out the bytes of a capture command with odd bit counts, and it checks both the padded final byte and the stretched low phase. The identification-word case needs a real TAP on the pins. The bench therefore carries a small behavioural TAP that loads a known word in Capture-DR. That TAP is reached only through a mode 0 state walk followed by a mode 3 capture.

// File: rtl/jtsh_pkg.sv
package jtsh_pkg;
  typedef enum logic [1:0] {
    M_TMS  = 2'd0,
    M_TDI  = 2'd1,
    M_BOTH = 2'd2,
    M_CAPT = 2'd3
  } jmode_t;

  typedef enum logic [2:0] {
    S_HDR,
    S_CNT,
    S_NEED,
    S_LOW,
    S_HIGH
  } jstate_t;
endpackage

// File: rtl/jtsh_tck_timer.sv
module jtsh_tck_timer #(
  parameter int HP_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [HP_W-1:0] half_period,
  output logic            tick
);
  logic [HP_W-1:0] cnt;
  logic [HP_W-1:0] lim;

  assign lim  = (half_period == '0) ? HP_W'(1) : half_period;
  assign tick = run && (cnt == lim - HP_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + HP_W'(1);
  end
endmodule

// File: rtl/jtsh_tdo_packer.sv
module jtsh_tdo_packer #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample,
  input  logic              last,
  input  logic              tdo,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_valid
);
  localparam int IDX_W = $clog2(BYTE_W);

  logic [BYTE_W-1:0] acc;
  logic [BYTE_W-1:0] merged;
  logic [IDX_W-1:0]  idx;

  assign merged = acc | (BYTE_W'(tdo) << idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      idx       <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (sample) begin
        if (idx == IDX_W'(BYTE_W - 1) || last) begin
          out_data  <= merged;
          out_valid <= 1'b1;
          acc       <= '0;
          idx       <= '0;
        end else begin
          acc <= merged;
          idx <= idx + IDX_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/jtag_bit_shifter.sv
module jtag_bit_shifter #(
  parameter int CNT_W = 16,
  parameter int HP_W  = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [7:0]      in_data,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [HP_W-1:0] half_period,
  output logic            tck,
  output logic            tms,
  output logic            tdi,
  input  logic            tdo,
  output logic [7:0]      out_data,
  output logic            out_valid
);
  import jtsh_pkg::*;

  localparam int CNT_BYTES = CNT_W / 8;
  localparam int CIDX_W    = (CNT_BYTES > 1) ? $clog2(CNT_BYTES) : 1;

  jstate_t           state;
  jmode_t            mode_q;
  logic              hold_q;
  logic [CIDX_W-1:0] cidx;
  logic [CNT_W-1:0]  remain;
  logic [CNT_W-1:0]  cnt_merged;
  logic [7:0]        dbyte;
  logic [7:0]        src;
  logic [7:0]        shifted;
  logic [2:0]        dleft;
  logic              accept;
  logic              dual;
  logic              n_tms;
  logic              n_tdi;
  logic              tick;

  assign in_ready = (state == S_HDR) || (state == S_CNT) || (state == S_NEED);
  assign accept   = in_valid && in_ready;
  assign dual     = mode_q[1];
  assign src      = (state == S_NEED) ? in_data : dbyte;
  assign shifted  = dual ? (src >> 2) : (src >> 1);

  always_comb begin
    cnt_merged = remain;
    for (int i = 0; i < CNT_BYTES; i++) begin
      if (cidx == CIDX_W'(i)) cnt_merged[i*8 +: 8] = in_data;
    end
  end

  always_comb begin
    case (mode_q)
      M_TMS:   begin n_tms = src[0]; n_tdi = hold_q; end
      M_TDI:   begin n_tms = hold_q; n_tdi = src[0]; end
      default: begin n_tms = src[1]; n_tdi = src[0]; end
    endcase
  end

  jtsh_tck_timer #(.HP_W(HP_W)) u_timer (
    .clk         (clk),
    .rst         (rst),
    .run         ((state == S_LOW) || (state == S_HIGH)),
    .half_period (half_period),
    .tick        (tick)
  );

  jtsh_tdo_packer #(.BYTE_W(8)) u_packer (
    .clk       (clk),
    .rst       (rst),
    .sample    ((state == S_LOW) && tick && (mode_q == M_CAPT)),
    .last      (remain == CNT_W'(1)),
    .tdo       (tdo),
    .out_data  (out_data),
    .out_valid (out_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_HDR;
      mode_q <= M_TMS;
      hold_q <= 1'b0;
      cidx   <= '0;
      remain <= '0;
      dbyte  <= '0;
      dleft  <= '0;
      tck    <= 1'b0;
      tms    <= 1'b1;
      tdi    <= 1'b0;
    end else begin
      case (state)
        S_HDR: if (accept) begin
          mode_q <= jmode_t'(in_data[1:0]);
          hold_q <= in_data[2];
          cidx   <= '0;
          state  <= S_CNT;
        end
        S_CNT: if (accept) begin
          remain <= cnt_merged;
          if (cidx == CIDX_W'(CNT_BYTES - 1))
            state <= (cnt_merged == '0) ? S_HDR : S_NEED;
          else
            cidx <= cidx + CIDX_W'(1);
        end
        S_NEED: if (accept) begin
          tms   <= n_tms;
          tdi   <= n_tdi;
          dbyte <= shifted;
          dleft <= dual ? 3'd3 : 3'd7;
          state <= S_LOW;
        end
        S_LOW: if (tick) begin
          tck    <= 1'b1;
          remain <= remain - CNT_W'(1);
          state  <= S_HIGH;
        end
        S_HIGH: if (tick) begin
          tck <= 1'b0;
          if (remain == '0) begin
            state <= S_HDR;
          end else if (dleft == 3'd0) begin
            state <= S_NEED;
          end else begin
            tms   <= n_tms;
            tdi   <= n_tdi;
            dbyte <= shifted;
            dleft <= dleft - 3'd1;
            state <= S_LOW;
          end
        end
        default: state <= S_HDR;
      endcase
    end
  end
endmodule

// File: rtl/jtsh_chk.sv
module jtsh_chk #(
  parameter int HP_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            tck,
  input logic            tms,
  input logic            tdi,
  input logic            in_ready,
  input logic            out_valid,
  input logic [HP_W-1:0] half_period,
  input logic [1:0]      mode_q,
  input logic            hold_q,
  input logic            shifting
);
  logic [HP_W:0] hcnt;
  logic [HP_W:0] lim;

  assign lim = (half_period == '0) ? (HP_W+1)'(1) : {1'b0, half_period};

  always_ff @(posedge clk) begin
    if (rst)      hcnt <= '0;
    else if (tck) hcnt <= hcnt + (HP_W+1)'(1);
    else          hcnt <= '0;
  end

  // R7
  pins_still_high_chk: assert property (@(posedge clk) disable iff (rst)
    tck |-> ($stable(tms) && $stable(tdi)));

  // R7
  high_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(tck) |-> (hcnt == lim));

  // R6
  out_at_rise_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $rose(tck));

  // R10
  ready_low_chk: assert property (@(posedge clk) disable iff (rst)
    tck |-> !in_ready);

  // R3
  tdi_held_chk: assert property (@(posedge clk) disable iff (rst)
    (shifting && mode_q == 2'd0) |-> (tdi == hold_q));

  // R4
  tms_held_chk: assert property (@(posedge clk) disable iff (rst)
    (shifting && mode_q == 2'd1) |-> (tms == hold_q));
endmodule

bind jtag_bit_shifter jtsh_chk #(.HP_W(HP_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .tck         (tck),
  .tms         (tms),
  .tdi         (tdi),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .half_period (half_period),
  .mode_q      (mode_q),
  .hold_q      (hold_q),
  .shifting    (state == jtsh_pkg::S_HIGH)
);

// File: tb/jtag_bit_shifter_bench.sv
module jtag_bit_shifter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HP_W       = 8;
  localparam int WATCHDOG   = 150000;
  localparam logic [31:0] DEV_ID = 32'h4A51_7093;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [7:0]      in_data = '0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [HP_W-1:0] half_period = 8'd2;
  logic            tck, tms, tdi;
  logic            tdo = 1'b0;
  logic [7:0]      out_data;
  logic            out_valid;

  always #(CLK_PERIOD/2) clk = ~clk;

  jtag_bit_shifter #(.CNT_W(16), .HP_W(HP_W)) u_jtag_bit_shifter (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .half_period(half_period), .tck(tck), .tms(tms),
    .tdi(tdi), .tdo(tdo), .out_data(out_data), .out_valid(out_valid)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int rise_cnt = 0;

  bit        q_tms[$], q_tdi[$], q_cap[$], q_last[$];
  string     q_tag[$];
  logic [7:0] q_out[$];
  logic [7:0] got_out[$];
  logic [7:0] cmd_data[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Behavioural TAP and TDO source
  typedef enum int {T_TLR, T_RTI, T_SEL, T_CAP, T_SH, T_OTH} tap_t;
  tap_t        tap = T_OTH;
  int          ones = 0;
  logic [31:0] dr = '0;
  logic [15:0] lfsr = 16'hACE1;

  always @(posedge tck) begin
    if (tap == T_SH)  dr = {tdi, dr[31:1]};
    if (tap == T_CAP) dr = DEV_ID;
    if (tms) ones++; else ones = 0;
    if (tms && ones >= 5) tap = T_TLR;
    else case (tap)
      T_TLR: tap = tms ? T_TLR : T_RTI;
      T_RTI: tap = tms ? T_SEL : T_RTI;
      T_SEL: tap = tms ? T_OTH : T_CAP;
      T_CAP: tap = tms ? T_OTH : T_SH;
      T_SH:  tap = tms ? T_OTH : T_SH;
      default: tap = T_OTH;
    endcase
  end

  always @(negedge tck) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tdo  = (tap == T_SH) ? dr[0] : lfsr[0];
  end

  // Reference monitor, compared on every clock
  bit         prev_tck = 1'b0;
  int         hi_len = 0;
  int         lo_len = 1000;
  int         eff_hp;
  logic [7:0] cap_acc = '0;
  int         cap_k = 0;

  always @(negedge clk) begin
    if (!rst) begin
      eff_hp = (half_period == 0) ? 1 : int'(half_period);
      if (tck && !prev_tck) begin
        rise_cnt++;
        if (q_tms.size() == 0) begin
          check(1'b0, "R8", "unexpected TCK rise", 1, 0);
        end else begin
          bit e_tms, e_tdi, e_cap, e_last;
          string tg;
          e_tms = q_tms.pop_front(); e_tdi = q_tdi.pop_front();
          e_cap = q_cap.pop_front(); e_last = q_last.pop_front();
          tg = q_tag.pop_front();
          check(tms == e_tms, tg, "TMS at rise", tms, e_tms);
          check(tdi == e_tdi, tg, "TDI at rise", tdi, e_tdi);
          check(!in_ready, "R10", "in_ready while TCK high", in_ready, 0);
          check(lo_len >= eff_hp, "R7", "TCK low phase", lo_len, eff_hp);
          if (e_cap) begin
            cap_acc = cap_acc | (8'(tdo) << cap_k);
            cap_k++;
            if (cap_k == 8 || e_last) begin
              q_out.push_back(cap_acc);
              cap_acc = '0;
              cap_k = 0;
            end
          end
        end
      end
      if (tck) begin
        if (!prev_tck) hi_len = 0;
        hi_len++;
      end else begin
        if (prev_tck) begin
          check(hi_len == eff_hp, "R7", "TCK high phase", hi_len, eff_hp);
          lo_len = 0;
        end
        lo_len++;
      end
      if (out_valid) begin
        if (q_out.size() == 0) begin
          check(1'b0, "R6", "unexpected output byte", out_data, 0);
        end else begin
          logic [7:0] e;
          e = q_out.pop_front();
          check(out_data == e, "R6", "captured byte", out_data, e);
        end
        got_out.push_back(out_data);
      end
      prev_tck = tck;
    end
  end

  task automatic send_byte(input logic [7:0] b, input int gap);
    repeat (gap) @(negedge clk);
    in_data  = b;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_cmd(input int mode, input bit hold, input logic [7:0] extra,
                         input int count, input int gap);
    bit    dual;
    int    nbytes;
    string tg;
    dual = (mode >= 2);
    tg = (mode == 0) ? "R3" : (mode == 1) ? "R4" : "R5";
    for (int i = 0; i < count; i++) begin
      bit b, e_tms, e_tdi;
      if (dual) begin
        e_tdi = cmd_data[i/4][2*(i%4)];
        e_tms = cmd_data[i/4][2*(i%4)+1];
      end else begin
        b = cmd_data[i/8][i%8];
        e_tms = (mode == 0) ? b : hold;
        e_tdi = (mode == 0) ? hold : b;
      end
      q_tms.push_back(e_tms); q_tdi.push_back(e_tdi);
      q_cap.push_back(mode == 3); q_last.push_back(i == count - 1);
      q_tag.push_back(tg);
    end
    nbytes = (count == 0) ? 0 : dual ? (count + 3) / 4 : (count + 7) / 8;
    send_byte({extra[7:3], hold, 2'(mode)}, 0);
    send_byte(8'(count), 0);
    send_byte(8'(count >> 8), 0);
    for (int i = 0; i < nbytes; i++) send_byte(cmd_data[i], gap);
    while (q_tms.size() != 0 || tck || !in_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      checks++;
      failures++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", cyc, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int base;
    int r0;
    logic [31:0] id;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(tck == 1'b0, "R1", "tck after reset", tck, 0);
    check(tms == 1'b1, "R1", "tms after reset", tms, 1);
    check(tdi == 1'b0, "R1", "tdi after reset", tdi, 0);
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

    // R3 / R11: walk TAP to Shift-DR
    half_period = 8'd2;
    cmd_data = '{8'h5F, 8'h00};
    run_cmd(0, 1'b0, 8'h00, 9, 0);

    // R11 / R6 / R5: capture identification word
    base = got_out.size();
    cmd_data = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    run_cmd(3, 1'b0, 8'h00, 32, 0);
    check(got_out.size() == base + 4, "R11", "ID byte count", got_out.size() - base, 4);
    if (got_out.size() == base + 4) begin
      id = {got_out[base+3], got_out[base+2], got_out[base+1], got_out[base]};
      check(id == DEV_ID, "R11", "identification word", id, DEV_ID);
    end

    // R4 with stalled data (R7 low phase stretch)
    half_period = 8'd3;
    cmd_data = '{8'hA5, 8'h1C};
    run_cmd(1, 1'b1, 8'h00, 13, 7);

    // R5 dual drive
    half_period = 8'd1;
    cmd_data = '{8'h9C, 8'h03};
    run_cmd(2, 1'b0, 8'h00, 6, 0);

    // R6 partial padded byte, R7 half_period 0 acts as 1
    half_period = 8'd0;
    cmd_data = '{8'h3A, 8'hC5, 8'h0F};
    run_cmd(3, 1'b0, 8'h00, 11, 0);

    // R8 zero count with reserved bits set
    r0 = rise_cnt;
    base = got_out.size();
    cmd_data.delete();
    run_cmd(3, 1'b0, 8'hF8, 0, 0);
    repeat (30) @(negedge clk);
    check(rise_cnt == r0, "R8", "no TCK for zero count", rise_cnt - r0, 0);
    check(got_out.size() == base, "R8", "no output for zero count", got_out.size() - base, 0);
    check(in_ready == 1'b1, "R8", "ready for header", in_ready, 1);

    // R2 reserved header bits, R9 count ends mid-byte
    half_period = 8'd2;
    cmd_data = '{8'h05};
    run_cmd(0, 1'b1, 8'hA8, 3, 0);
    // R9 next byte taken as header
    cmd_data = '{8'hF0};
    run_cmd(1, 1'b0, 8'h00, 8, 0);

    // R6 / R7 longer capture with gaps
    half_period = 8'd4;
    cmd_data = '{8'h6B, 8'h21, 8'hFE, 8'h90, 8'h47};
    run_cmd(3, 1'b0, 8'h00, 17, 3);

    repeat (10) @(negedge clk);
    check(q_tms.size() == 0, "R2", "all expected clocks seen", q_tms.size(), 0);
    check(q_out.size() == 0, "R6", "all expected bytes seen", q_out.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule